// File: doc/BRIEF.md
# Flash Status and Write-Guard Unit

This unit keeps the status byte of a small serial flash array and decides, cycle by cycle, whether a program/erase request or a status update may go ahead. The SPI front-end hands it one-cycle command strobes: set write-enable, clear write-enable, and a status update that comes with its data byte. The unit also watches the chip-select line, the active-low write-protect pin, a busy flag from the array program sequencer, and the address that a pending array write targets.

Protection depends on three things together: the write-enable latch, the protect-enable bit and the write-protect pin. Which addresses are locked depends on the two block-protect bits and on the array size, which is a parameter (two or four 32 KiB blocks). A status update does not take effect at once. It is held until chip-select goes high and then runs as a timed internal cycle. During that cycle the unit reports busy, and the new bits land when the cycle ends.

Top module: `wp_status_ctrl`

## Requirements
- R1: When idle, the status byte reads as follows: bit7 protect-enable, bits 6..4 zero, bits 3..2 block-protect, bit1 write-enable latch, bit0 zero.
- R2: While the internal status cycle or the sequencer busy input is active, the status byte reads 8'hFF and no write is allowed.
- R3: After reset, the latch, the block-protect bits and protect-enable are all zero, so the status byte reads 8'h00.
- R4: The set-write-enable strobe sets the latch. The clear-write-enable strobe clears it whatever the write-protect pin level.
- R5: With the latch clear, both the array-write and status-write permissions are 0.
- R6: Four-block array, with the block index in address bits [16:15]: block-protect 00 locks nothing, 01 locks block 3, 10 locks blocks 2 and 3, and 11 locks every block. An unlocked address with the latch set is allowed.
- R7: Two-block array: only block-protect 11 locks anything, and it locks the whole array. Values 01 and 10 lock nothing.
- R8: When the pin is low and protect-enable is 1, status writes are denied. A status update strobe is then ignored, so protect-enable stays 1.
- R9: An accepted status update takes data bit7 as protect-enable and bits 3..2 as block-protect. The busy cycle starts on the first clock that sees chip-select high and lasts SRW_CYCLES clocks. At its end the new bits appear and the latch clears.
- R10: If the pin is low while protect-enable is 1, with the update pending and chip-select still low, the update is dropped: no busy cycle runs and the status is unchanged. Once the busy cycle has begun, the pin has no effect on it.
- R11: The latch clears on the clock after the sequencer busy input falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip-select, active low |
| wp_n | input | 1 | Write-protect pin, active low |
| cmd_wren | input | 1 | Set write-enable strobe |
| cmd_wrdi | input | 1 | Clear write-enable strobe |
| cmd_wrsr | input | 1 | Status update strobe |
| wrsr_data | input | 8 | Status update data byte |
| seq_busy | input | 1 | Array sequencer busy |
| chk_addr | input | AW | Address of the array write being checked |
| status_out | output | 8 | Status byte for reads |
| array_wr_ok | output | 1 | Array write at chk_addr allowed |
| sr_wr_ok | output | 1 | Status write allowed |

## Verification
Strobes and pin changes are registered, so the latch, pending-update and status effects appear one clock after the edge that samples them. The busy cycle is visible one clock after chip-select rises and stays up for exactly SRW_CYCLES clocks. The permission outputs are combinational from state and address, so an address change shows in the same cycle. The bench drives on falling edges and samples on the next falling edge, so each registered result is read exactly one clock after its cause. The status cycle is checked as busy right after chip-select rises, and as committed after SRW_CYCLES further clocks.

// File: rtl/wp_status_ctrl.sv
module wp_status_ctrl #(
  parameter int NUM_BLOCKS = 4,
  parameter int BLOCK_AW   = 15,
  parameter int SRW_CYCLES = 8,
  localparam int AW = BLOCK_AW + $clog2(NUM_BLOCKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          wp_n,
  input  logic          cmd_wren,
  input  logic          cmd_wrdi,
  input  logic          cmd_wrsr,
  input  logic [7:0]    wrsr_data,
  input  logic          seq_busy,
  input  logic [AW-1:0] chk_addr,
  output logic [7:0]    status_out,
  output logic          array_wr_ok,
  output logic          sr_wr_ok
);
  localparam int CW = $clog2(SRW_CYCLES + 1);

  logic          wel, wpen, pend, sr_busy, seq_q;
  logic [1:0]    bp;
  logic [2:0]    pend_bits;
  logic [CW-1:0] cnt;
  logic          busy, hw_lock, locked;

  assign busy    = sr_busy | seq_busy;
  assign hw_lock = wpen & ~wp_n;

  generate
    if (NUM_BLOCKS == 4) begin : g_quad
      logic [1:0] blk;
      assign blk    = chk_addr[AW-1 -: 2];
      assign locked = (bp == 2'b11) | (bp == 2'b10 & blk[1]) | (bp == 2'b01 & blk == 2'b11);
    end else begin : g_pair
      assign locked = (bp == 2'b11);
    end
  endgenerate

  assign array_wr_ok = wel & ~busy & ~locked;
  assign sr_wr_ok    = wel & ~busy & ~hw_lock;
  assign status_out  = busy ? 8'hFF : {wpen, 3'b000, bp, wel, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel <= 1'b0; wpen <= 1'b0; bp <= 2'b00; pend <= 1'b0;
      pend_bits <= 3'b000; sr_busy <= 1'b0; cnt <= '0; seq_q <= 1'b0;
    end else begin
      seq_q <= seq_busy;
      if (sr_busy) begin
        if (cnt == '0) begin
          sr_busy <= 1'b0;
          wpen    <= pend_bits[2];
          bp      <= pend_bits[1:0];
          wel     <= 1'b0;
        end else begin
          cnt <= cnt - CW'(1);
        end
      end else if (seq_q && !seq_busy) begin
        wel <= 1'b0;
      end else if (!seq_busy) begin
        if (pend) begin
          if (hw_lock) pend <= 1'b0;
          else if (cs_n) begin
            pend    <= 1'b0;
            sr_busy <= 1'b1;
            cnt     <= CW'(SRW_CYCLES - 1);
          end
        end else if (cmd_wrsr && sr_wr_ok) begin
          pend      <= 1'b1;
          pend_bits <= {wrsr_data[7], wrsr_data[3:2]};
        end else if (cmd_wren) begin
          wel <= 1'b1;
        end else if (cmd_wrdi) begin
          wel <= 1'b0;
        end
      end
    end
  end

  a_r9_wel_clear_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr_busy) |-> !wel);
  a_r5_cycle_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_busy) |-> $past(wel));
  a_r8_wpen_held: assert property (@(posedge clk) disable iff (!rst_n)
    (wpen && !wp_n && !sr_busy) |=> wpen);
  a_r6_full_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (status_out[3:2] == 2'b11 && !busy) |-> !array_wr_ok);
  a_r11_wel_clear_seq: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(seq_busy) && !sr_busy) |=> !wel);
endmodule

// File: tb/wp_status_ctrl_test.sv
module wp_status_ctrl_test;
  localparam int PERIOD = 10;
  localparam int SRW = 8;
  localparam logic [7:0] MAP [16] = '{
    8'h03, 8'h13, 8'h23, 8'h33,
    8'h43, 8'h53, 8'h63, 8'h71,
    8'h83, 8'h93, 8'hA1, 8'hB1,
    8'hC0, 8'hD0, 8'hE0, 8'hF0};

  logic clk = 0, rst_n = 0, cs_n = 1, wp_n = 1;
  logic cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, seq_busy = 0;
  logic [7:0] wrsr_data = 0;
  logic [16:0] addr = 0;
  logic [7:0] st, st2;
  logic aok, sok, aok2, sok2;
  int errors = 0, checks = 0;

  always #(PERIOD/2) clk = ~clk;

  wp_status_ctrl #(.NUM_BLOCKS(4), .SRW_CYCLES(SRW)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .cmd_wren(cmd_wren),
    .cmd_wrdi(cmd_wrdi), .cmd_wrsr(cmd_wrsr), .wrsr_data(wrsr_data),
    .seq_busy(seq_busy), .chk_addr(addr), .status_out(st),
    .array_wr_ok(aok), .sr_wr_ok(sok));
  wp_status_ctrl #(.NUM_BLOCKS(2), .SRW_CYCLES(SRW)) uut_small (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .cmd_wren(cmd_wren),
    .cmd_wrdi(cmd_wrdi), .cmd_wrsr(cmd_wrsr), .wrsr_data(wrsr_data),
    .seq_busy(seq_busy), .chk_addr(addr[15:0]), .status_out(st2),
    .array_wr_ok(aok2), .sr_wr_ok(sok2));

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic wren();
    cmd_wren = 1; @(negedge clk); cmd_wren = 0;
  endtask
  task automatic wrdi();
    cmd_wrdi = 1; @(negedge clk); cmd_wrdi = 0;
  endtask
  task automatic wrsr(logic [7:0] d);
    cs_n = 0; cmd_wrsr = 1; wrsr_data = d; @(negedge clk);
    cmd_wrsr = 0; cs_n = 1; @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R3 reset status", st, 8'h00);
    chk("R3 reset status small", st2, 8'h00);
    chk("R5 no wel array", {7'b0, aok}, 8'h00);
    chk("R5 no wel status", {7'b0, sok}, 8'h00);
    rst_n = 1; @(negedge clk);
    wren();
    chk("R4 wren sets latch R1", st, 8'h02);
    chk("R4 array ok with wel", {7'b0, aok}, 8'h01);
    wrdi();
    chk("R4 wrdi clears latch", st, 8'h00);

    for (int i = 0; i < 16; i++) begin
      logic [7:0] row;
      row = MAP[i];
      wren();
      wrsr({4'b0, row[7:6], 2'b00});
      chk("R9 busy after cs rise R2", st, 8'hFF);
      chk("R2 no write while busy", {7'b0, aok | sok}, 8'h00);
      repeat (SRW) @(negedge clk);
      chk("R9 committed, wel cleared R1", st, {4'b0, row[7:6], 2'b00});
      wren();
      addr = {row[5:4], 15'h0123};
      @(negedge clk);
      chk("R6 four-block lock map", {7'b0, aok}, {7'b0, row[1]});
      chk("R7 two-block lock map", {7'b0, aok2}, {7'b0, row[0]});
      wrdi();
    end
    wren(); wrsr(8'h00); repeat (SRW) @(negedge clk);
    chk("R9 bp back to zero", st, 8'h00);

    wren();
    seq_busy = 1; @(negedge clk);
    chk("R2 seq busy reads ones", st, 8'hFF);
    seq_busy = 0; @(negedge clk);
    chk("R11 latch cleared after seq busy", st, 8'h00);

    wren(); wrsr(8'h80); repeat (SRW) @(negedge clk);
    chk("R9 wpen set R1", st, 8'h80);
    wren(); wp_n = 0; @(negedge clk);
    chk("R8 status write denied", {7'b0, sok}, 8'h00);
    wrsr(8'h00); @(negedge clk);
    chk("R8 wrsr ignored, wpen held", st, 8'h82);
    wrdi();
    chk("R4 wrdi with pin low", st, 8'h80);

    wp_n = 1; wren();
    cs_n = 0; cmd_wrsr = 1; wrsr_data = 8'h8C; @(negedge clk);
    cmd_wrsr = 0; wp_n = 0; @(negedge clk);
    wp_n = 1; cs_n = 1; @(negedge clk);
    chk("R10 aborted, no busy", st, 8'h82);
    @(negedge clk);
    chk("R10 aborted, status unchanged", st, 8'h82);

    cs_n = 0; cmd_wrsr = 1; wrsr_data = 8'h0C; @(negedge clk);
    cmd_wrsr = 0; cs_n = 1; @(negedge clk);
    chk("R10 cycle started", st, 8'hFF);
    wp_n = 0;
    repeat (SRW) @(negedge clk);
    chk("R10 pin ignored once begun", st, 8'h0C);
    wp_n = 1;
    finish_run();
  end
endmodule